// File: doc/BRIEF.md
# Banked Stack Pointer Selector

This block keeps two banked stack pointer registers, a main pointer and a process pointer. It presents one of them as the current stack pointer. A select bit held in a control register chooses the bank, and the execution mode can override it. In handler mode the main pointer is always current. In thread mode the select bit decides. Push and pop requests always act on the current pointer, and the other bank keeps its value.

After reset the block asks for one word from a fixed boot address and loads the returned word into the main pointer. Until that word arrives the block reports busy and ignores push and pop requests. All pointer values are word aligned. Push and pop follow a full descending model: a push moves the current pointer down by four bytes and a pop moves it up by four. Software writes to either bank directly, and writes to the control register to change the select bit.

Top module: `stkptr_bank`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the select bit is 0, both pointers read 0, `busy` and `fetch_req` are 1, and `fetch_addr` is 0x0000_0000.
- R2: A cycle with `busy` and `fetch_valid` both high loads `fetch_data`, with its two low bits cleared, into the main pointer. From the next cycle `busy` and `fetch_req` are 0 and stay 0 until the next reset.
- R3: While `busy` is 1, `push_req` and `pop_req` change neither pointer.
- R4: In thread mode (`handler_mode` = 0), `cur_sp` equals the main pointer when the select bit is 0 and the process pointer when it is 1.
- R5: In handler mode (`handler_mode` = 1), `cur_sp` equals the main pointer whatever the select bit holds.
- R6: When not busy, a push alone lowers the current pointer by 4 and a pop alone raises it by 4, wrapping modulo 2^32. A push and a pop in the same cycle leave it unchanged.
- R7: A push or pop never changes the bank that is not current.
- R8: Every value loaded into a pointer, by direct write or by boot fetch, has bits [1:0] forced to 0.
- R9: A control write with `ctl_wr_en` sets the select bit from bit 1 of `ctl_wr_data` and ignores all other bits. `cur_sp` shows the new selection only from the cycle after the write.
- R10: A direct write to a bank in the same cycle as a push or pop aimed at that bank wins. The bank takes the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| handler_mode | input | 1 | 1 = handler mode, 0 = thread mode |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 32 | Control write value; bit 1 is the select bit |
| main_wr_en | input | 1 | Direct write strobe for the main pointer |
| main_wr_data | input | 32 | Direct write value for the main pointer |
| proc_wr_en | input | 1 | Direct write strobe for the process pointer |
| proc_wr_data | input | 32 | Direct write value for the process pointer |
| push_req | input | 1 | Push: current pointer minus 4 |
| pop_req | input | 1 | Pop: current pointer plus 4 |
| fetch_valid | input | 1 | Boot fetch response valid |
| fetch_data | input | 32 | Boot fetch response word |
| fetch_req | output | 1 | Boot fetch request, high until the response |
| fetch_addr | output | 32 | Boot fetch address, fixed at 0x0000_0000 |
| busy | output | 1 | High until the main pointer has been loaded |
| cur_sp | output | 32 | Current stack pointer |
| main_sp | output | 32 | Main pointer value |
| proc_sp | output | 32 | Process pointer value |

## Verification
The bench pushes and pops while the boot fetch is still pending. A design that did not gate these requests would move the main pointer before it was loaded. The bench switches the select bit while in handler mode to show that the mode override holds. It also checks `cur_sp` in the cycle of a control write, where a design that took a same-cycle path would switch one cycle too early. It writes a process pointer and pushes on it in the same cycle, where the wrong priority would leave the value 4 below the written one. It sends misaligned writes and fetch words, and a control value with every bit set except the select bit. A design that kept the low bits, or decoded the wrong control bit, would show a wrong pointer value or the wrong bank.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;

    localparam int unsigned DEF_PTR_W     = 32;
    localparam int unsigned DEF_STEP      = 4;
    localparam int unsigned DEF_ALIGN_LSB = 2;
    localparam int unsigned DEF_SEL_BIT   = 1;
    localparam int unsigned NUM_BANKS     = 2;

    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_DEC  = 2'd1,
        UPD_INC  = 2'd2
    } upd_op_e;

    typedef enum logic {
        BANK_MAIN = 1'b0,
        BANK_PROC = 1'b1
    } bank_e;

    typedef enum logic {
        BOOT_FETCH = 1'b0,
        BOOT_RUN   = 1'b1
    } boot_state_e;

    // push lowers, pop raises; both together cancel
    function automatic upd_op_e decode_op(input logic push, input logic pop);
        if (push && !pop)      return UPD_DEC;
        else if (pop && !push) return UPD_INC;
        else                   return UPD_NONE;
    endfunction

    function automatic bank_e pick_bank(input logic handler, input logic sel);
        return (!handler && sel) ? BANK_PROC : BANK_MAIN;
    endfunction

endpackage

// File: rtl/stkptr_boot.sv
module stkptr_boot
    import stkptr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fetch_valid,
    output logic busy,
    output logic fetch_req,
    output logic load_main
);
    boot_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= BOOT_FETCH;
        else if (state_q == BOOT_FETCH && fetch_valid)
            state_q <= BOOT_RUN;
    end

    assign busy      = (state_q == BOOT_FETCH);
    assign fetch_req = busy;
    assign load_main = busy && fetch_valid;

    // R2: response ends the busy phase, which never returns without reset
    p_busy_ends_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && fetch_valid) |=> !busy);
    p_busy_stays_low_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !busy);

endmodule

// File: rtl/stkptr_select.sv
module stkptr_select
    import stkptr_pkg::*;
#(
    parameter int unsigned CTL_W   = 32,
    parameter int unsigned SEL_BIT = DEF_SEL_BIT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             handler_mode,
    input  logic             ctl_wr_en,
    input  logic [CTL_W-1:0] ctl_wr_data,
    output logic             sel_q,
    output bank_e            active
);
    localparam logic [CTL_W-1:0] SEL_MASK = CTL_W'(1) << SEL_BIT;

    logic sel_d;
    assign sel_d = |(ctl_wr_data & SEL_MASK);

    always_ff @(posedge clk) begin
        if (rst)            sel_q <= 1'b0;
        else if (ctl_wr_en) sel_q <= sel_d;
    end

    assign active = pick_bank(handler_mode, sel_q);

    // R9: the select bit follows bit SEL_BIT of the write one cycle later
    p_ctl_next_cycle_r9: assert property (@(posedge clk) disable iff (rst)
        ctl_wr_en |=> (sel_q == $past(ctl_wr_data[SEL_BIT])));
    // R5: handler mode never points at the process bank
    p_handler_main_r5: assert property (@(posedge clk) disable iff (rst)
        handler_mode |-> (active == BANK_MAIN));

endmodule

// File: rtl/stkptr_bank_reg.sv
module stkptr_bank_reg
    import stkptr_pkg::*;
#(
    parameter int unsigned W         = DEF_PTR_W,
    parameter int unsigned STEP      = DEF_STEP,
    parameter int unsigned ALIGN_LSB = DEF_ALIGN_LSB
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic [W-1:0] load_data,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  upd_op_e      op,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] MASK   = {W{1'b1}} << ALIGN_LSB;
    localparam logic [W-1:0] STEP_V = W'(STEP);

    logic [W-1:0] q;

    // priority: boot load, then direct write, then push/pop step
    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (load_en) q <= load_data & MASK;
        else if (wr_en)   q <= wr_data & MASK;
        else begin
            case (op)
                UPD_DEC: q <= q - STEP_V;
                UPD_INC: q <= q + STEP_V;
                default: q <= q;
            endcase
        end
    end

    assign value = q;

    // R8: stored pointer keeps its alignment bits clear
    p_aligned_r8: assert property (@(posedge clk) disable iff (rst)
        (q & ~MASK) == '0);

endmodule

// File: rtl/stkptr_bank.sv
module stkptr_bank
    import stkptr_pkg::*;
#(
    parameter int unsigned PTR_W          = DEF_PTR_W,
    parameter int unsigned CTL_W          = 32,
    parameter int unsigned SEL_BIT        = DEF_SEL_BIT,
    parameter int unsigned STEP           = DEF_STEP,
    parameter int unsigned ALIGN_LSB      = DEF_ALIGN_LSB,
    parameter logic [31:0] BOOT_ADDR      = 32'h0000_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             handler_mode,
    input  logic             ctl_wr_en,
    input  logic [CTL_W-1:0] ctl_wr_data,
    input  logic             main_wr_en,
    input  logic [PTR_W-1:0] main_wr_data,
    input  logic             proc_wr_en,
    input  logic [PTR_W-1:0] proc_wr_data,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic             fetch_valid,
    input  logic [PTR_W-1:0] fetch_data,
    output logic             fetch_req,
    output logic [31:0]      fetch_addr,
    output logic             busy,
    output logic [PTR_W-1:0] cur_sp,
    output logic [PTR_W-1:0] main_sp,
    output logic [PTR_W-1:0] proc_sp
);
    localparam logic [PTR_W-1:0] STEP_V = PTR_W'(STEP);
    localparam logic [PTR_W-1:0] MASK   = {PTR_W{1'b1}} << ALIGN_LSB;

    logic    load_main;
    logic    sel_q;
    bank_e   active;
    upd_op_e req_op;

    logic             bank_load    [NUM_BANKS];
    logic             bank_wr_en   [NUM_BANKS];
    logic [PTR_W-1:0] bank_wr_data [NUM_BANKS];
    upd_op_e          bank_op      [NUM_BANKS];
    logic [PTR_W-1:0] bank_val     [NUM_BANKS];

    stkptr_boot u_boot (
        .clk        (clk),
        .rst        (rst),
        .fetch_valid(fetch_valid),
        .busy       (busy),
        .fetch_req  (fetch_req),
        .load_main  (load_main)
    );

    stkptr_select #(.CTL_W(CTL_W), .SEL_BIT(SEL_BIT)) u_sel (
        .clk         (clk),
        .rst         (rst),
        .handler_mode(handler_mode),
        .ctl_wr_en   (ctl_wr_en),
        .ctl_wr_data (ctl_wr_data),
        .sel_q       (sel_q),
        .active      (active)
    );

    assign req_op = busy ? UPD_NONE : decode_op(push_req, pop_req);

    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            bank_op[b]   = (int'(active) == b) ? req_op : UPD_NONE;
            bank_load[b] = (b == int'(BANK_MAIN)) ? load_main : 1'b0;
        end
        bank_wr_en[BANK_MAIN]   = main_wr_en;
        bank_wr_data[BANK_MAIN] = main_wr_data;
        bank_wr_en[BANK_PROC]   = proc_wr_en;
        bank_wr_data[BANK_PROC] = proc_wr_data;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        stkptr_bank_reg #(.W(PTR_W), .STEP(STEP), .ALIGN_LSB(ALIGN_LSB)) u_reg (
            .clk      (clk),
            .rst      (rst),
            .load_en  (bank_load[b]),
            .load_data(fetch_data),
            .wr_en    (bank_wr_en[b]),
            .wr_data  (bank_wr_data[b]),
            .op       (bank_op[b]),
            .value    (bank_val[b])
        );
    end

    assign main_sp    = bank_val[BANK_MAIN];
    assign proc_sp    = bank_val[BANK_PROC];
    assign cur_sp     = bank_val[active];
    assign fetch_addr = BOOT_ADDR;

    // R1: reset leaves the block waiting for its boot word with main selected
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (busy && fetch_req && !sel_q && main_sp == '0 && proc_sp == '0));
    // R2: boot word lands aligned in the main pointer
    p_boot_load_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && fetch_valid) |=> (main_sp == ($past(fetch_data) & MASK)));
    // R3: no movement of the process bank while busy unless written
    p_busy_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !proc_wr_en) |=> $stable(proc_sp));
    // R5: handler mode presents the main pointer
    p_handler_cur_r5: assert property (@(posedge clk) disable iff (rst)
        handler_mode |-> (cur_sp == main_sp));
    // R6: lone push on the process bank steps it down by one word
    p_push_step_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && push_req && !pop_req && active == BANK_PROC && !proc_wr_en)
        |=> (proc_sp == $past(proc_sp) - STEP_V));
    // R6: lone pop on the main bank steps it up by one word
    p_pop_step_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && pop_req && !push_req && active == BANK_MAIN && !main_wr_en)
        |=> (main_sp == $past(main_sp) + STEP_V));
    // R7: the bank not selected is untouched by push/pop
    p_other_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && (push_req ^ pop_req) && active == BANK_PROC && !main_wr_en)
        |=> $stable(main_sp));
    // R10: direct write beats a same-cycle step
    p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && proc_wr_en) |=> (proc_sp == ($past(proc_wr_data) & MASK)));

endmodule

// File: tb/sim_stkptr_bank.sv
module sim_stkptr_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    typedef struct packed {
        logic        hnd;
        logic        cw;
        logic [31:0] cd;
        logic        pw;
        logic [31:0] pd;
        logic        push;
        logic        pop;
        logic [31:0] ec;
        logic [31:0] em;
        logic [31:0] ep;
    } vec_t;

    // starting state: main 0x2000_0400, process 0, select 0
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,32'h0,1'b1,32'h1000_0807,1'b0,1'b0,32'h2000_0400,32'h2000_0400,32'h1000_0804}, // R8 R4
        '{1'b0,1'b0,32'h0,1'b0,32'h0,1'b1,1'b0,32'h2000_03FC,32'h2000_03FC,32'h1000_0804},        // R6 push main
        '{1'b0,1'b0,32'h0,1'b0,32'h0,1'b0,1'b1,32'h2000_0400,32'h2000_0400,32'h1000_0804},        // R6 pop main
        '{1'b0,1'b1,32'h2,1'b0,32'h0,1'b0,1'b0,32'h1000_0804,32'h2000_0400,32'h1000_0804},        // R4 select proc
        '{1'b0,1'b0,32'h0,1'b0,32'h0,1'b1,1'b0,32'h1000_0800,32'h2000_0400,32'h1000_0800},        // R7
        '{1'b0,1'b0,32'h0,1'b0,32'h0,1'b1,1'b0,32'h1000_07FC,32'h2000_0400,32'h1000_07FC},        // R6
        '{1'b1,1'b0,32'h0,1'b0,32'h0,1'b0,1'b1,32'h2000_0404,32'h2000_0404,32'h1000_07FC},        // R5 pop in handler
        '{1'b1,1'b0,32'h0,1'b0,32'h0,1'b0,1'b0,32'h2000_0404,32'h2000_0404,32'h1000_07FC},        // R5
        '{1'b0,1'b0,32'h0,1'b0,32'h0,1'b0,1'b0,32'h1000_07FC,32'h2000_0404,32'h1000_07FC},        // R4
        '{1'b0,1'b0,32'h0,1'b0,32'h0,1'b1,1'b1,32'h1000_07FC,32'h2000_0404,32'h1000_07FC},        // R6 both
        '{1'b0,1'b1,32'hFFFF_FFFD,1'b0,32'h0,1'b0,1'b0,32'h2000_0404,32'h2000_0404,32'h1000_07FC}, // R9
        '{1'b1,1'b1,32'h2,1'b0,32'h0,1'b0,1'b0,32'h2000_0404,32'h2000_0404,32'h1000_07FC},        // R5
        '{1'b0,1'b0,32'h0,1'b0,32'h0,1'b0,1'b1,32'h1000_0800,32'h2000_0404,32'h1000_0800}         // R4 R6
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        handler_mode = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [31:0] ctl_wr_data = '0;
    logic        main_wr_en = 1'b0;
    logic [31:0] main_wr_data = '0;
    logic        proc_wr_en = 1'b0;
    logic [31:0] proc_wr_data = '0;
    logic        push_req = 1'b0;
    logic        pop_req = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_data = '0;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic        busy;
    logic [31:0] cur_sp, main_sp, proc_sp;

    int n_chk = 0;
    int n_fail = 0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stkptr_bank u0 (
        .clk(clk), .rst(rst), .handler_mode(handler_mode),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .main_wr_en(main_wr_en), .main_wr_data(main_wr_data),
        .proc_wr_en(proc_wr_en), .proc_wr_data(proc_wr_data),
        .push_req(push_req), .pop_req(pop_req),
        .fetch_valid(fetch_valid), .fetch_data(fetch_data),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .busy(busy),
        .cur_sp(cur_sp), .main_sp(main_sp), .proc_sp(proc_sp)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ctl_wr_en = 1'b0; main_wr_en = 1'b0; proc_wr_en = 1'b0;
        push_req = 1'b0; pop_req = 1'b0; fetch_valid = 1'b0;
    endtask

    task automatic next();
        @(negedge clk);
    endtask

    initial begin
        next(); next();
        rst = 1'b0;
        // R1: reset state
        chk("R1", "busy", {31'b0, busy}, 32'h1);
        chk("R1", "fetch_req", {31'b0, fetch_req}, 32'h1);
        chk("R1", "fetch_addr", fetch_addr, 32'h0);
        chk("R1", "cur_sp", cur_sp, 32'h0);
        chk("R1", "proc_sp", proc_sp, 32'h0);
        // R3: push then pop while busy
        push_req = 1'b1;
        next();
        chk("R3", "main after push", main_sp, 32'h0);
        push_req = 1'b0; pop_req = 1'b1;
        next();
        chk("R3", "main after pop", main_sp, 32'h0);
        chk("R3", "still busy", {31'b0, busy}, 32'h1);
        pop_req = 1'b0;
        // R2 R8: boot word with low bits set
        fetch_valid = 1'b1; fetch_data = 32'h2000_0403;
        next();
        fetch_valid = 1'b0;
        chk("R2", "main loaded", main_sp, 32'h2000_0400);
        chk("R2", "busy low", {31'b0, busy}, 32'h0);
        chk("R2", "fetch_req low", {31'b0, fetch_req}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            handler_mode = VECS[i].hnd;
            ctl_wr_en = VECS[i].cw;  ctl_wr_data = VECS[i].cd;
            proc_wr_en = VECS[i].pw; proc_wr_data = VECS[i].pd;
            push_req = VECS[i].push; pop_req = VECS[i].pop;
            next();
            chk("R4-vector", $sformatf("cur %0d", i), cur_sp, VECS[i].ec);
            chk("R6-vector", $sformatf("main %0d", i), main_sp, VECS[i].em);
            chk("R7-vector", $sformatf("proc %0d", i), proc_sp, VECS[i].ep);
            idle_inputs();
        end

        // now: thread, select 1, main 0x2000_0404, process 0x1000_0800
        // R10: write and push to process bank together
        handler_mode = 1'b0;
        proc_wr_en = 1'b1; proc_wr_data = 32'h3000_0000; push_req = 1'b1;
        next();
        idle_inputs();
        chk("R10", "write beats push", proc_sp, 32'h3000_0000);
        // R9: clearing select shows only after the edge
        ctl_wr_en = 1'b1; ctl_wr_data = 32'h0;
        #1;
        chk("R9", "cur before edge", cur_sp, 32'h3000_0000);
        next();
        idle_inputs();
        chk("R9", "cur after edge", cur_sp, 32'h2000_0404);
        // R8: misaligned direct write to main
        main_wr_en = 1'b1; main_wr_data = 32'h4000_0002;
        next();
        idle_inputs();
        chk("R8", "main aligned", main_sp, 32'h4000_0000);
        // R6: wrap below zero
        main_wr_en = 1'b1; main_wr_data = 32'h0;
        next();
        idle_inputs();
        push_req = 1'b1;
        next();
        idle_inputs();
        chk("R6", "wrap", main_sp, 32'hFFFF_FFFC);
        // R1: second reset
        rst = 1'b1;
        next();
        rst = 1'b0;
        chk("R1", "busy again", {31'b0, busy}, 32'h1);
        chk("R1", "main cleared", main_sp, 32'h0);
        chk("R1", "proc cleared", proc_sp, 32'h0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule